// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block derives the serial bit clock and the left/right frame clock of an audio converter from an external master clock. It applies when the converter acts as clock master with its internal PLL bypassed. A 4-bit mode code sets the ratio of master clock to sample rate fs. The lowest three bits pick one of 256, 384, 512, 768 or 1024 times fs, and the top bit is ignored. A separate select bit sets the frame length to 32 or 64 bit clocks.

Both clocks come from counters running on the master clock, so no clock is gated. The divider handles ratios that are not powers of two (384 and 768). Each bit-clock period is a whole number of master-clock cycles, and each frame is exactly one sample long. When the code is invalid, or the block is not enabled as a PLL-bypassed master, both outputs sit low. Any change to the configuration restarts the output at the start of a left half-frame.

Top module: `serial_clock_master`

## Requirements
- R1: Clocks run only when `enable_i`=1, `pll_on_i`=0 and `clk_master_i`=1. In any other combination, `bclk_o` and `fclk_o` are low from the next master-clock edge onward.
- R2: With `wide_frame_i`=0, the code in `rate_sel_i[2:0]` sets the ratio R as follows: 000 gives 256, 001 gives 1024, 100 gives 384, 101 gives 768, 110 gives 512 and 111 gives 256. The `bclk_o` period is then R/32 master-clock cycles (32 fs).
- R3: With `wide_frame_i`=1, the `bclk_o` period is R/64 master-clock cycles (64 fs).
- R4: `rate_sel_i[3]` has no effect on the selected ratio or on the output periods.
- R5: Codes 010 and 011 in `rate_sel_i[2:0]` are invalid. One master-clock cycle after such a code is applied, `cfg_bad_o` is high and both clocks are low. Both conditions hold until a valid code is applied, and then `cfg_bad_o` falls one cycle later.
- R6: `bclk_o` has a 50 % duty cycle: it is high for half its period.
- R7: `fclk_o` has a period of R master-clock cycles and is high for R/2 cycles, giving 16 or 32 bit clocks per half-frame. It changes level only together with a falling edge of `bclk_o`. It is low during the left half-frame and high during the right half-frame.
- R8: Any change to `rate_sel_i`, `wide_frame_i`, `enable_i`, `pll_on_i` or `clk_master_i` restarts the output. On the next edge both clocks go low. `bclk_o` first rises R/(64 or 128) edges later, while `fclk_o` stays low for that first left half-frame.
- R9: While `arst_ni` is low, `bclk_o`, `fclk_o` and `cfg_bad_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | External master clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 4 | Master-clock-to-fs ratio code; bit 3 ignored |
| wide_frame_i | input | 1 | 0: 32 bit clocks per frame, 1: 64 |
| pll_on_i | input | 1 | PLL enable; must be 0 for output |
| clk_master_i | input | 1 | Master/slave select; must be 1 for output |
| enable_i | input | 1 | Block enable |
| bclk_o | output | 1 | Serial bit clock |
| fclk_o | output | 1 | Frame (word-select) clock, low = left |
| cfg_bad_o | output | 1 | Invalid ratio code flag |

## Verification
A corrupted half-period counter or a wrong decoded terminal count shows up within one bit-clock period, at most 32 master-clock cycles. It appears as a `bclk_o` period or high time that differs from R/32 or R/64. A wrong half-frame bit count, or a frame toggle that is not tied to the bit-clock fall, appears within one frame, at most 1024 master-clock cycles. It shows as an `fclk_o` period other than R or as an `fclk_o` edge without a matching `bclk_o` fall. Restart faults appear within the first few cycles after a configuration change, as a non-low clock or an early first rising edge.

// File: rtl/scm_pkg.sv
package scm_pkg;

   // Ratio of master clock to fs for a 3-bit code; 0 marks an unusable code.
   function automatic int unsigned scm_ratio(input logic [2:0] code);
      case (code)
         3'b000, 3'b111: return 256;
         3'b001:         return 1024;
         3'b100:         return 384;
         3'b101:         return 768;
         3'b110:         return 512;
         default:        return 0;
      endcase
   endfunction

   localparam int unsigned SCM_NARROW_HALF_BITS = 16;
   localparam int unsigned SCM_WIDE_HALF_BITS   = 32;

endpackage

// File: rtl/scm_rate_decode.sv
module scm_rate_decode
   import scm_pkg::*;
#(
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned BIT_W    = 5,
   parameter bit          FLAG_REG = 1'b1
)(
   input  logic             clk,
   input  logic             arst_n,
   input  logic [2:0]       code,
   input  logic             wide,
   output logic             valid_o,
   output logic [CNT_W-1:0] half_m1_o,
   output logic [BIT_W-1:0] bits_m1_o,
   output logic             bad_o
);

   int unsigned ratio;
   int unsigned half_len;

   always_comb begin
      ratio     = scm_ratio(code);
      valid_o   = (ratio != 0);
      // half bit-clock period = ratio / (2 * bits per frame)
      half_len  = wide ? (ratio >> 7) : (ratio >> 6);
      half_m1_o = valid_o ? CNT_W'(half_len - 1) : '0;
      bits_m1_o = wide ? BIT_W'(SCM_WIDE_HALF_BITS - 1)
                       : BIT_W'(SCM_NARROW_HALF_BITS - 1);
   end

   generate
      if (FLAG_REG) begin : g_flag_ff
         logic bad_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) bad_q <= 1'b0;
            else         bad_q <= !valid_o;
         end
         assign bad_o = bad_q;
      end else begin : g_flag_comb
         assign bad_o = !valid_o;
      end
   endgenerate

endmodule

// File: rtl/scm_bit_divider.sv
module scm_bit_divider #(
   parameter int unsigned CNT_W = 4
)(
   input  logic             clk,
   input  logic             arst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] half_m1,
   output logic             bclk_o,
   output logic             fall_now_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             bclk_q;
   logic             term;

   assign term       = (cnt_q == half_m1);
   // asserted in the cycle whose closing edge drops the bit clock
   assign fall_now_o = run && !restart && term && bclk_q;
   assign bclk_o     = bclk_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (!run || restart) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (term) begin
         cnt_q  <= '0;
         bclk_q <= !bclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R1: an idle divider leaves the bit clock low
   p_bclk_idle_r1: assert property (@(posedge clk) disable iff (!arst_n)
      !run |=> !bclk_q);

   // R6: the count never passes the half-period terminal value
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!arst_n)
      (run && !restart) |-> (cnt_q <= half_m1));

   // R6: level held for the whole half period
   p_bclk_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
      (run && !restart && !term) |=> $stable(bclk_q));

endmodule

// File: rtl/scm_frame_counter.sv
module scm_frame_counter #(
   parameter int unsigned BIT_W = 5
)(
   input  logic             clk,
   input  logic             arst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             fall_now,
   input  logic [BIT_W-1:0] bits_m1,
   output logic             fclk_o
);

   logic [BIT_W-1:0] bits_q;
   logic             fclk_q;

   assign fclk_o = fclk_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         bits_q <= '0;
         fclk_q <= 1'b0;
      end else if (!run || restart) begin
         bits_q <= '0;
         fclk_q <= 1'b0;
      end else if (fall_now) begin
         if (bits_q == bits_m1) begin
            bits_q <= '0;
            fclk_q <= !fclk_q;
         end else begin
            bits_q <= bits_q + 1'b1;
         end
      end
   end

   // R7: no frame-clock change without a bit-clock fall at the same edge
   p_fclk_on_fall_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (run && !restart && !fall_now) |=> $stable(fclk_q));

   // R7: half-frame bit count stays within its frame length
   p_bits_bound_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (run && !restart) |-> (bits_q <= bits_m1));

endmodule

// File: rtl/serial_clock_master.sv
module serial_clock_master #(
   parameter int unsigned MAX_RATIO     = 1024,
   parameter int unsigned MAX_HALF_BITS = 32,
   parameter bit          FLAG_REG      = 1'b1
)(
   input  logic       mclk_i,
   input  logic       arst_ni,
   input  logic [3:0] rate_sel_i,
   input  logic       wide_frame_i,
   input  logic       pll_on_i,
   input  logic       clk_master_i,
   input  logic       enable_i,
   output logic       bclk_o,
   output logic       fclk_o,
   output logic       cfg_bad_o
);

   localparam int unsigned CNT_W = $clog2(MAX_RATIO / 64);
   localparam int unsigned BIT_W = $clog2(MAX_HALF_BITS);
   localparam int unsigned KEY_W = 4 + 4;

   generate
      if (MAX_RATIO < 1024 || (MAX_RATIO % 128) != 0) begin : g_bad_ratio
         $error("MAX_RATIO must be a multiple of 128 and at least 1024");
      end
      if (MAX_HALF_BITS < 32) begin : g_bad_bits
         $error("MAX_HALF_BITS must be at least 32");
      end
   endgenerate

   logic             valid;
   logic [CNT_W-1:0] half_m1;
   logic [BIT_W-1:0] bits_m1;
   logic             run;
   logic             restart;
   logic             fall_now;
   logic [KEY_W-1:0] key;
   logic [KEY_W-1:0] key_q;

   assign key     = {rate_sel_i, wide_frame_i, enable_i, pll_on_i, clk_master_i};
   assign restart = (key != key_q);
   assign run     = enable_i && !pll_on_i && clk_master_i && valid;

   always_ff @(posedge mclk_i or negedge arst_ni) begin
      if (!arst_ni) key_q <= '0;
      else          key_q <= key;
   end

   scm_rate_decode #(
      .CNT_W    (CNT_W),
      .BIT_W    (BIT_W),
      .FLAG_REG (FLAG_REG)
   ) i_decode (
      .clk       (mclk_i),
      .arst_n    (arst_ni),
      .code      (rate_sel_i[2:0]),
      .wide      (wide_frame_i),
      .valid_o   (valid),
      .half_m1_o (half_m1),
      .bits_m1_o (bits_m1),
      .bad_o     (cfg_bad_o)
   );

   scm_bit_divider #(
      .CNT_W (CNT_W)
   ) i_bdiv (
      .clk        (mclk_i),
      .arst_n     (arst_ni),
      .run        (run),
      .restart    (restart),
      .half_m1    (half_m1),
      .bclk_o     (bclk_o),
      .fall_now_o (fall_now)
   );

   scm_frame_counter #(
      .BIT_W (BIT_W)
   ) i_frame (
      .clk      (mclk_i),
      .arst_n   (arst_ni),
      .run      (run),
      .restart  (restart),
      .fall_now (fall_now),
      .bits_m1  (bits_m1),
      .fclk_o   (fclk_o)
   );

   // R1: outside PLL-bypassed master operation both clocks drop
   p_idle_mode_r1: assert property (@(posedge mclk_i) disable iff (!arst_ni)
      !(enable_i && !pll_on_i && clk_master_i) |=> (!bclk_o && !fclk_o));

   // R5: a standing invalid-code flag comes with quiet clocks
   p_bad_quiet_r5: assert property (@(posedge mclk_i) disable iff (!arst_ni)
      (cfg_bad_o && $past(cfg_bad_o)) |-> (!bclk_o && !fclk_o));

   // R8: a configuration change returns both clocks low
   p_restart_low_r8: assert property (@(posedge mclk_i) disable iff (!arst_ni)
      restart |=> (!bclk_o && !fclk_o));

endmodule

// File: tb/test_serial_clock_master.sv
module test_serial_clock_master;

   typedef struct {
      int    bper;
      int    bhigh;
      int    fper;
      int    fhigh;
      string tag;
   } exp_t;

   logic       mclk = 1'b0;
   logic       arst_n = 1'b0;
   logic [3:0] rate_sel = 4'b0111;
   logic       wide = 1'b0;
   logic       pll_on = 1'b0;
   logic       master = 1'b1;
   logic       en = 1'b1;
   logic       bclk, fclk, bad;

   int checks = 0;
   int failures = 0;

   exp_t exp_q[$];
   logic arm = 1'b0;
   logic mon_done = 1'b0;

   always #5 mclk = !mclk;

   serial_clock_master i_serial_clock_master (
      .mclk_i       (mclk),
      .arst_ni      (arst_n),
      .rate_sel_i   (rate_sel),
      .wide_frame_i (wide),
      .pll_on_i     (pll_on),
      .clk_master_i (master),
      .enable_i     (en),
      .bclk_o       (bclk),
      .fclk_o       (fclk),
      .cfg_bad_o    (bad)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ratio_for(input logic [2:0] c);
      case (c)
         3'b001: return 1024;
         3'b100: return 384;
         3'b101: return 768;
         3'b110: return 512;
         default: return 256;
      endcase
   endfunction

   // ---------------- monitor / scoreboard ----------------
   int cyc = 0;
   int mstate = 0;
   logic pb = 1'b0, pf = 1'b0;
   int last_brise = 0, last_frise = 0;
   int bper = 0, bhigh = 0, fper = 0, fhigh = 0;
   int edge_bad = 0;

   always @(negedge mclk) begin
      cyc++;
      if (!arm) begin
         mstate   = 0;
         mon_done = 1'b0;
         edge_bad = 0;
      end else if (mstate == 0) begin
         mstate = 1;
      end
      if (mstate >= 1 && fclk != pf && !(pb && !bclk)) edge_bad++;
      if (bclk && !pb) begin
         bper = cyc - last_brise;
         last_brise = cyc;
      end
      if (!bclk && pb) bhigh = cyc - last_brise;
      if (!fclk && pf) fhigh = cyc - last_frise;
      if (fclk && !pf) begin
         fper = cyc - last_frise;
         last_frise = cyc;
         if (mstate == 1) begin
            mstate = 2;
         end else if (mstate == 2) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "scoreboard empty", 0, 1);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(bper == e.bper,   {e.tag, " bclk period"}, bper, e.bper);
               chk(bhigh == e.bhigh, {e.tag, " R6 bclk high time"}, bhigh, e.bhigh);
               chk(fper == e.fper,   {e.tag, " R7 fclk period"}, fper, e.fper);
               chk(fhigh == e.fhigh, {e.tag, " R7 fclk high time"}, fhigh, e.fhigh);
               chk(edge_bad == 0,    {e.tag, " R7 fclk edge on bclk fall"}, edge_bad, 0);
            end
            mstate   = 3;
            mon_done = 1'b1;
         end
      end
      pb = bclk;
      pf = fclk;
   end

   // ---------------- driver ----------------
   task automatic measure(input logic [3:0] code, input logic w, input string tag);
      exp_t e;
      int r;
      @(negedge mclk);
      rate_sel = code;
      wide     = w;
      repeat (4) @(negedge mclk);
      r       = ratio_for(code[2:0]);
      e.bper  = w ? r / 64 : r / 32;
      e.bhigh = e.bper / 2;
      e.fper  = r;
      e.fhigh = r / 2;
      e.tag   = tag;
      exp_q.push_back(e);
      arm = 1'b1;
      wait (mon_done);
      @(negedge mclk);
      arm = 1'b0;
      @(negedge mclk);
   endtask

   task automatic quiet_window(input int n, input string req);
      int seen = 0;
      repeat (2) @(negedge mclk);
      for (int i = 0; i < n; i++) begin
         @(negedge mclk);
         if (bclk || fclk) seen++;
      end
      chk(seen == 0, req, seen, 0);
   endtask

   initial begin
      logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
      // R9: reset state
      repeat (3) @(negedge mclk);
      chk({bclk, fclk, bad} == 3'b000, "R9 outputs low in reset", {bclk, fclk, bad}, 0);
      @(negedge mclk);
      arst_n = 1'b1;

      // R2 / R3: every valid code with both frame lengths
      for (int w = 0; w < 2; w++) begin
         for (int k = 0; k < 6; k++) begin
            measure({1'b0, codes[k]}, w[0], w == 0 ? "R2" : "R3");
         end
      end

      // R4: top mode bit has no effect
      measure(4'b1100, 1'b0, "R4 code 1100");
      measure(4'b1001, 1'b1, "R4 code 1001");

      // R1: each disabling condition silences the outputs
      rate_sel = 4'b0111; wide = 1'b0;
      pll_on = 1'b1;  quiet_window(100, "R1 pll on");   pll_on = 1'b0;
      master = 1'b0;  quiet_window(100, "R1 slave");    master = 1'b1;
      en = 1'b0;      quiet_window(100, "R1 disabled"); en = 1'b1;

      // R5: invalid codes
      rate_sel = 4'b0010;
      repeat (2) @(negedge mclk);
      chk(bad == 1'b1, "R5 flag for 010", bad, 1);
      quiet_window(80, "R5 quiet on 010");
      rate_sel = 4'b0011;
      repeat (2) @(negedge mclk);
      chk(bad == 1'b1, "R5 flag for 011", bad, 1);
      quiet_window(80, "R5 quiet on 011");
      rate_sel = 4'b0111;
      repeat (2) @(negedge mclk);
      chk(bad == 1'b0, "R5 flag clears on valid code", bad, 0);

      // R8: restart timing, 256 fs narrow -> 256 fs wide (half period 2)
      repeat (37) @(negedge mclk);
      wide = 1'b1;
      @(negedge mclk);
      chk({bclk, fclk} == 2'b00, "R8 low after restart edge", {bclk, fclk}, 0);
      @(negedge mclk);
      chk(bclk == 1'b0, "R8 bclk still low one edge later", bclk, 0);
      @(negedge mclk);
      chk(bclk == 1'b1, "R8 first bclk rise at half period", bclk, 1);
      chk(fclk == 1'b0, "R8 starts in left half-frame", fclk, 0);

      // R8: restart from 768 fs narrow (half period 12)
      rate_sel = 4'b0101; wide = 1'b0;
      repeat (12) @(negedge mclk);
      chk(bclk == 1'b0, "R8 768fs bclk low before half period", bclk, 0);
      @(negedge mclk);
      chk(bclk == 1'b1, "R8 768fs first rise", bclk, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge mclk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule